// File: doc/BRIEF.md
# Power Domain Gating Sequencer

This block walks one switchable power island through its power-up and power-down procedures in hardware. It is given a single request, on or off. It then changes the island's controls one at a time: the two power-switch stages, the clock gate, the isolation clamps, the active-low domain reset and the SRAM power-down lines. Between these steps it waits on feedback from the island. That feedback is a pair of power-good indications, a bus of SRAM power-down acknowledges and the interconnect's bus-protection status. Every wait has a time limit. If a wait runs out, the block halts where it stands and reports an error.

The controls leave the block as one packed control word. Bit 0 is the active-low reset (1 releases it), bit 1 enables isolation, bit 2 is the first power-switch stage, bit 3 is the second stage and bit 4 disables the clock. Bits 7:5 read zero. Bits 11:8 are the SRAM power-down lines. Three static configuration inputs tailor the block to one domain: a mask of the SRAM lines the domain owns, a mask of the acknowledge lanes it answers with, and a bus-protection mask. Nothing moves until an unlock word has been written: upper half 0x0B16 and bit 0 set. The end of every sequence is signalled by a one-cycle done pulse, with an error flag beside it.

Top module: `pwr_domain_seq`

## Requirements
- R1: After reset the control word is 0xF12 (reset asserted, isolation on, clock disabled, both power stages off, all four SRAM power-down lines set), the protection-enable output is zero, and done and err are low.
- R2: A request is ignored until an unlock write has been seen whose bits 31:16 equal 0x0B16 and whose bit 0 is 1. Writes with a different upper half, or with bit 0 clear, do not unlock the block.
- R3: A power-on request (req_on=1) performs these steps in order: set bit 2, set bit 3, wait for domain-on, clear bit 4, clear bit 1, set bit 0, clear the configured SRAM lines, wait for the acknowledges to clear, then release bus protection. Each step takes its own clock cycle, so bits 4:0 change at most one at a time.
- R4: A power-off request (req_on=0) performs these steps in order: engage bus protection and wait for it, set the configured SRAM lines, wait for the acknowledges to be full, set bit 1, clear bit 0, set bit 4, clear bit 2, clear bit 3, then wait for domain-off. Each step takes its own cycle.
- R5: The domain counts as on only when both status inputs are 1, and as off only when both are 0. A disagreement between them satisfies neither wait.
- R6: The SRAM waits consider only the acknowledge lanes set in cfg_ack_mask. The power-on wait needs all of those lanes at 0, and the power-off wait needs all of them at 1. An all-zero mask passes at once.
- R7: Engaging protection ORs cfg_prot_mask into prot_en and waits until every masked bit of prot_sta is 1. Releasing it clears those bits of prot_en and waits until every masked bit of prot_sta is 0.
- R8: When cfg_prot_mask is zero, both protection steps are skipped and prot_en keeps its value. Power-on then finishes two cycles sooner than it would against a protection status that answers one cycle after prot_en changes.
- R9: If a wait is not satisfied on 100 consecutive evaluations, the sequence stops. The controls keep their present values, and done and err pulse together.
- R10: Every sequence ends with done high for exactly one cycle. err is high in that cycle only when a wait timed out.
- R11: A request that arrives while a sequence is running is ignored.
- R12: Only the SRAM lines selected by cfg_sram_mask are set on power-off or cleared on power-on. The other lines keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| unlock_wr | input | 1 | Unlock word is valid this cycle |
| unlock_data | input | 32 | Unlock word (0x0B16 in 31:16 and bit 0 set to unlock) |
| req_valid | input | 1 | Sequence request strobe |
| req_on | input | 1 | 1 = power on, 0 = power off |
| cfg_sram_mask | input | 4 | SRAM power-down lines owned by the domain |
| cfg_ack_mask | input | 4 | SRAM acknowledge lanes used by the domain |
| cfg_prot_mask | input | 32 | Bus-protection bits of the domain |
| pwr_stat_a | input | 1 | First power-good indication |
| pwr_stat_b | input | 1 | Second power-good indication |
| sram_ack | input | 4 | SRAM power-down acknowledges |
| prot_sta | input | 32 | Bus-protection status from the interconnect |
| ctrl_word | output | 12 | Packed domain controls, layout as described above |
| prot_en | output | 32 | Bus-protection enables |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | Set with done when a wait timed out |

## Verification
All outputs are registered. A request sampled at clock edge k shows its first control change just after edge k. Each later action step shows up one edge after the one before it. A wait is evaluated on every edge after the one that entered it, using the inputs sampled at that edge, and it advances or fails on that same edge. The bench models this as a queue of pending actions and waits that is advanced once per rising edge. It drives inputs and compares the control word, prot_en, done and err at the falling edge, which keeps every comparison half a cycle away from the edge that moved them. The island model in the bench answers each control change one cycle late. This exercises the mismatch window between the two status inputs and the one-cycle lag of the acknowledges and protection status. The scenario checks read the final outputs in the cycle in which done is seen.

// File: rtl/pds_pkg.sv
package pds_pkg;

  // control word bit positions (a downstream island decodes these)
  localparam int B_RSTN   = 0;
  localparam int B_ISO    = 1;
  localparam int B_PON    = 2;
  localparam int B_PON2   = 3;
  localparam int B_CLKDIS = 4;
  localparam int SRAM_LO  = 8;

  localparam logic [15:0] UNLOCK_KEY = 16'h0B16;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_U_PON2,
    ST_U_WON,
    ST_U_ISO,
    ST_U_RST,
    ST_U_SRAM,
    ST_U_WACK,
    ST_U_WPROT,
    ST_D_WPROT,
    ST_D_WACK,
    ST_D_RST,
    ST_D_CLK,
    ST_D_PON,
    ST_D_PON2,
    ST_D_WOFF
  } seq_state_e;

endpackage

// File: rtl/pds_unlock.sv
module pds_unlock
  import pds_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  logic [15:0] key_half,
  input  logic        en_bit,
  output logic        unlocked
);

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked <= 1'b0;
    end else if (wr && (key_half == UNLOCK_KEY) && en_bit) begin
      unlocked <= 1'b1;
    end
  end

  // R2: once set, the unlock flag stays set until reset
  assert_unlock_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    unlocked |=> unlocked);

endmodule

// File: rtl/pds_cond.sv
module pds_cond #(
  parameter int SRAM_W = 4,
  parameter int PROT_W = 32
) (
  input  logic              stat_a,
  input  logic              stat_b,
  input  logic [SRAM_W-1:0] ack,
  input  logic [SRAM_W-1:0] ack_mask,
  input  logic [PROT_W-1:0] prot_sta,
  input  logic [PROT_W-1:0] prot_mask,
  output logic              dom_on,
  output logic              dom_off,
  output logic              ack_clear,
  output logic              ack_full,
  output logic              prot_set,
  output logic              prot_clr
);

  logic [SRAM_W-1:0] ack_sel;
  logic [PROT_W-1:0] prot_sel;

  always_comb begin
    ack_sel   = ack & ack_mask;
    prot_sel  = prot_sta & prot_mask;
    dom_on    = stat_a & stat_b;
    dom_off   = ~stat_a & ~stat_b;
    ack_clear = (ack_sel == '0);
    ack_full  = (ack_sel == ack_mask);
    prot_set  = (prot_sel == prot_mask);
    prot_clr  = (prot_sel == '0);
  end

endmodule

// File: rtl/pds_wait_timer.sv
module pds_wait_timer #(
  parameter int TIMEOUT = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic waiting,
  input  logic satisfied,
  output logic expired
);

  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt;

  assign expired = waiting && !satisfied && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (waiting && !satisfied && !expired) begin
      cnt <= cnt + 1'b1;
    end else begin
      cnt <= '0;
    end
  end

  // R9: the count never runs past the timeout window
  assert_timer_bound_R9: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(TIMEOUT));

  // R9: an expiry restarts the count for the next wait
  assert_timer_restart_R9: assert property (@(posedge clk) disable iff (rst)
    expired |=> (cnt == '0));

endmodule

// File: rtl/pds_fsm.sv
module pds_fsm
  import pds_pkg::*;
#(
  parameter int SRAM_W = 4,
  parameter int PROT_W = 32,
  localparam int CTRL_W = SRAM_LO + SRAM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              unlocked,
  input  logic              req_valid,
  input  logic              req_on,
  input  logic [SRAM_W-1:0] sram_mask,
  input  logic [PROT_W-1:0] prot_mask,
  input  logic              dom_on,
  input  logic              dom_off,
  input  logic              ack_clear,
  input  logic              ack_full,
  input  logic              prot_set,
  input  logic              prot_clr,
  input  logic              expired,
  output logic              waiting,
  output logic              satisfied,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [PROT_W-1:0] prot_q,
  output logic              done_q,
  output logic              err_q
);

  seq_state_e        state;
  logic [CTRL_W-1:0] ctrl_rst_v;
  logic              has_prot;

  always_comb begin
    ctrl_rst_v                     = '0;
    ctrl_rst_v[B_ISO]              = 1'b1;
    ctrl_rst_v[B_CLKDIS]           = 1'b1;
    ctrl_rst_v[SRAM_LO +: SRAM_W]  = '1;
  end

  assign has_prot = |prot_mask;

  always_comb begin
    waiting   = 1'b0;
    satisfied = 1'b0;
    case (state)
      ST_U_WON:   begin waiting = 1'b1; satisfied = dom_on;    end
      ST_U_WACK:  begin waiting = 1'b1; satisfied = ack_clear; end
      ST_U_WPROT: begin waiting = 1'b1; satisfied = prot_clr;  end
      ST_D_WPROT: begin waiting = 1'b1; satisfied = prot_set;  end
      ST_D_WACK:  begin waiting = 1'b1; satisfied = ack_full;  end
      ST_D_WOFF:  begin waiting = 1'b1; satisfied = dom_off;   end
      default:    begin waiting = 1'b0; satisfied = 1'b0;      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      ctrl_q <= ctrl_rst_v;
      prot_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (waiting && !satisfied) begin
        if (expired) begin
          done_q <= 1'b1;
          err_q  <= 1'b1;
          state  <= ST_IDLE;
        end
      end else begin
        case (state)
          ST_IDLE: begin
            if (unlocked && req_valid) begin
              if (req_on) begin
                ctrl_q[B_PON] <= 1'b1;
                state         <= ST_U_PON2;
              end else if (has_prot) begin
                prot_q <= prot_q | prot_mask;
                state  <= ST_D_WPROT;
              end else begin
                ctrl_q[SRAM_LO +: SRAM_W] <= ctrl_q[SRAM_LO +: SRAM_W] | sram_mask;
                state                     <= ST_D_WACK;
              end
            end
          end
          ST_U_PON2: begin
            ctrl_q[B_PON2] <= 1'b1;
            state          <= ST_U_WON;
          end
          ST_U_WON: begin
            ctrl_q[B_CLKDIS] <= 1'b0;
            state            <= ST_U_ISO;
          end
          ST_U_ISO: begin
            ctrl_q[B_ISO] <= 1'b0;
            state         <= ST_U_RST;
          end
          ST_U_RST: begin
            ctrl_q[B_RSTN] <= 1'b1;
            state          <= ST_U_SRAM;
          end
          ST_U_SRAM: begin
            ctrl_q[SRAM_LO +: SRAM_W] <= ctrl_q[SRAM_LO +: SRAM_W] & ~sram_mask;
            state                     <= ST_U_WACK;
          end
          ST_U_WACK: begin
            if (has_prot) begin
              prot_q <= prot_q & ~prot_mask;
              state  <= ST_U_WPROT;
            end else begin
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end
          end
          ST_U_WPROT: begin
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end
          ST_D_WPROT: begin
            ctrl_q[SRAM_LO +: SRAM_W] <= ctrl_q[SRAM_LO +: SRAM_W] | sram_mask;
            state                     <= ST_D_WACK;
          end
          ST_D_WACK: begin
            ctrl_q[B_ISO] <= 1'b1;
            state         <= ST_D_RST;
          end
          ST_D_RST: begin
            ctrl_q[B_RSTN] <= 1'b0;
            state          <= ST_D_CLK;
          end
          ST_D_CLK: begin
            ctrl_q[B_CLKDIS] <= 1'b1;
            state            <= ST_D_PON;
          end
          ST_D_PON: begin
            ctrl_q[B_PON] <= 1'b0;
            state         <= ST_D_PON2;
          end
          ST_D_PON2: begin
            ctrl_q[B_PON2] <= 1'b0;
            state          <= ST_D_WOFF;
          end
          ST_D_WOFF: begin
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R2: a locked block never leaves idle
  assert_locked_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !unlocked) |=> (state == ST_IDLE));

  // R3: the low control bits move one at a time
  assert_one_step_R3: assert property (@(posedge clk) disable iff (rst)
    $countones(ctrl_q[B_CLKDIS:B_RSTN] ^ $past(ctrl_q[B_CLKDIS:B_RSTN])) <= 1);

  // R3: reset is released only into a powered, clocked, unclamped domain
  assert_rst_release_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl_q[B_RSTN]) |-> (ctrl_q[B_PON] && ctrl_q[B_PON2] &&
                               !ctrl_q[B_CLKDIS] && !ctrl_q[B_ISO]));

  // R4: power is removed only after isolation, reset and clock gating
  assert_pwr_drop_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(ctrl_q[B_PON]) |-> (ctrl_q[B_ISO] && !ctrl_q[B_RSTN] && ctrl_q[B_CLKDIS]));

  // R8: a zero protection mask leaves the enables untouched
  assert_prot_skip_R8: assert property (@(posedge clk) disable iff (rst)
    (prot_mask == '0) |=> $stable(prot_q));

  // R9: err is only ever reported together with done
  assert_err_with_done_R9: assert property (@(posedge clk) disable iff (rst)
    err_q |-> done_q);

  // R10: done lasts a single cycle
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq
  import pds_pkg::*;
#(
  parameter int SRAM_W  = 4,
  parameter int PROT_W  = 32,
  parameter int TIMEOUT = 100,
  localparam int CTRL_W = SRAM_LO + SRAM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              unlock_wr,
  input  logic [31:0]       unlock_data,
  input  logic              req_valid,
  input  logic              req_on,
  input  logic [SRAM_W-1:0] cfg_sram_mask,
  input  logic [SRAM_W-1:0] cfg_ack_mask,
  input  logic [PROT_W-1:0] cfg_prot_mask,
  input  logic              pwr_stat_a,
  input  logic              pwr_stat_b,
  input  logic [SRAM_W-1:0] sram_ack,
  input  logic [PROT_W-1:0] prot_sta,
  output logic [CTRL_W-1:0] ctrl_word,
  output logic [PROT_W-1:0] prot_en,
  output logic              done,
  output logic              err
);

  logic unlocked;
  logic dom_on, dom_off, ack_clear, ack_full, prot_set, prot_clr;
  logic waiting, satisfied, expired;
  logic unused_mid_bits;

  assign unused_mid_bits = ^unlock_data[15:1];

  pds_unlock u_unlock (
    .clk      (clk),
    .rst      (rst),
    .wr       (unlock_wr),
    .key_half (unlock_data[31:16]),
    .en_bit   (unlock_data[0]),
    .unlocked (unlocked)
  );

  pds_cond #(
    .SRAM_W (SRAM_W),
    .PROT_W (PROT_W)
  ) u_cond (
    .stat_a    (pwr_stat_a),
    .stat_b    (pwr_stat_b),
    .ack       (sram_ack),
    .ack_mask  (cfg_ack_mask),
    .prot_sta  (prot_sta),
    .prot_mask (cfg_prot_mask),
    .dom_on    (dom_on),
    .dom_off   (dom_off),
    .ack_clear (ack_clear),
    .ack_full  (ack_full),
    .prot_set  (prot_set),
    .prot_clr  (prot_clr)
  );

  pds_wait_timer #(
    .TIMEOUT (TIMEOUT)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .waiting   (waiting),
    .satisfied (satisfied),
    .expired   (expired)
  );

  pds_fsm #(
    .SRAM_W (SRAM_W),
    .PROT_W (PROT_W)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .unlocked  (unlocked),
    .req_valid (req_valid),
    .req_on    (req_on),
    .sram_mask (cfg_sram_mask),
    .prot_mask (cfg_prot_mask),
    .dom_on    (dom_on),
    .dom_off   (dom_off),
    .ack_clear (ack_clear),
    .ack_full  (ack_full),
    .prot_set  (prot_set),
    .prot_clr  (prot_clr),
    .expired   (expired),
    .waiting   (waiting),
    .satisfied (satisfied),
    .ctrl_q    (ctrl_word),
    .prot_q    (prot_en),
    .done_q    (done),
    .err_q     (err)
  );

endmodule

// File: tb/pwr_domain_seq_test.sv
module pwr_domain_seq_test;

  localparam int SW  = 4;
  localparam int PW  = 32;
  localparam int TMO = 100;

  // model operation codes: actions below 20, waits from 20
  localparam int A_PON1 = 1,  A_PON2_1 = 2,  A_CLK0 = 3,  A_ISO0 = 4,  A_RST1 = 5;
  localparam int A_SCLR = 6,  A_PCLR = 7,    A_PSET = 8,  A_SSET = 9,  A_ISO1 = 10;
  localparam int A_RST0 = 11, A_CLK1 = 12,   A_PON0 = 13, A_PON2_0 = 14;
  localparam int W_ON = 20, W_ACK0 = 21, W_PROT0 = 22, W_PROT1 = 23, W_ACK1 = 24, W_OFF = 25;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst = 1'b1;
  logic          unlock_wr = 1'b0;
  logic [31:0]   unlock_data = '0;
  logic          req_valid = 1'b0;
  logic          req_on = 1'b0;
  logic [SW-1:0] cfg_sram = 4'hF;
  logic [SW-1:0] cfg_ack = 4'hF;
  logic [PW-1:0] cfg_prot = '0;
  logic          stat_a, stat_b;
  logic [SW-1:0] sram_ack;
  logic [PW-1:0] prot_sta;
  logic [11:0]   ctrl_word;
  logic [PW-1:0] prot_en;
  logic          done, err;

  logic hold_a = 0, hold_b = 0, hold_ack = 0, hold_prot = 0;

  int checks = 0;
  int errors = 0;

  pwr_domain_seq uut (
    .clk(clk), .rst(rst), .unlock_wr(unlock_wr), .unlock_data(unlock_data),
    .req_valid(req_valid), .req_on(req_on), .cfg_sram_mask(cfg_sram),
    .cfg_ack_mask(cfg_ack), .cfg_prot_mask(cfg_prot), .pwr_stat_a(stat_a),
    .pwr_stat_b(stat_b), .sram_ack(sram_ack), .prot_sta(prot_sta),
    .ctrl_word(ctrl_word), .prot_en(prot_en), .done(done), .err(err)
  );

  // island model: every indication follows its control one cycle late
  always @(posedge clk) begin
    if (rst) begin
      stat_a <= 1'b0; stat_b <= 1'b0; sram_ack <= '0; prot_sta <= '0;
    end else begin
      if (!hold_a)    stat_a   <= ctrl_word[2];
      if (!hold_b)    stat_b   <= ctrl_word[3];
      if (!hold_ack)  sram_ack <= ctrl_word[11:8];
      if (!hold_prot) prot_sta <= prot_en;
    end
  end

  // reference model: queue of pending steps, advanced once per edge
  int          q[$];
  int          wcnt;
  logic [11:0] m_ctrl;
  logic [PW-1:0] m_prot;
  logic        m_done, m_err, m_unl;
  string       m_tag = "R3";

  task automatic act(input int op);
    case (op)
      A_PON1:   m_ctrl[2] = 1'b1;
      A_PON2_1: m_ctrl[3] = 1'b1;
      A_CLK0:   m_ctrl[4] = 1'b0;
      A_ISO0:   m_ctrl[1] = 1'b0;
      A_RST1:   m_ctrl[0] = 1'b1;
      A_SCLR:   m_ctrl[11:8] = m_ctrl[11:8] & ~cfg_sram;
      A_PCLR:   m_prot = m_prot & ~cfg_prot;
      A_PSET:   m_prot = m_prot | cfg_prot;
      A_SSET:   m_ctrl[11:8] = m_ctrl[11:8] | cfg_sram;
      A_ISO1:   m_ctrl[1] = 1'b1;
      A_RST0:   m_ctrl[0] = 1'b0;
      A_CLK1:   m_ctrl[4] = 1'b1;
      A_PON0:   m_ctrl[2] = 1'b0;
      A_PON2_0: m_ctrl[3] = 1'b0;
      default: ;
    endcase
  endtask

  function automatic bit met(input int op);
    case (op)
      W_ON:    return stat_a && stat_b;
      W_OFF:   return !stat_a && !stat_b;
      W_ACK0:  return (sram_ack & cfg_ack) == '0;
      W_ACK1:  return (sram_ack & cfg_ack) == cfg_ack;
      W_PROT0: return (prot_sta & cfg_prot) == '0;
      W_PROT1: return (prot_sta & cfg_prot) == cfg_prot;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      q.delete(); wcnt = 0;
      m_ctrl = 12'hF12; m_prot = '0; m_done = 0; m_err = 0; m_unl = 0;
    end else begin
      m_done = 0; m_err = 0;
      if (q.size() == 0) begin
        if (m_unl && req_valid) begin
          if (req_on) begin
            m_tag = "R3";
            q = '{A_PON1, A_PON2_1, W_ON, A_CLK0, A_ISO0, A_RST1, A_SCLR, W_ACK0};
            if (cfg_prot != '0) begin q.push_back(A_PCLR); q.push_back(W_PROT0); end
          end else begin
            m_tag = "R4";
            q = '{A_SSET, W_ACK1, A_ISO1, A_RST0, A_CLK1, A_PON0, A_PON2_0, W_OFF};
            if (cfg_prot != '0) begin q.push_front(W_PROT1); q.push_front(A_PSET); end
          end
          act(q.pop_front());
          wcnt = 0;
        end
      end else if (q[0] >= 20) begin
        if (met(q[0])) begin
          void'(q.pop_front());
          wcnt = 0;
          if (q.size() == 0) m_done = 1;
          else act(q.pop_front());
        end else begin
          wcnt++;
          if (wcnt == TMO) begin
            m_done = 1; m_err = 1; q.delete(); wcnt = 0;
          end
        end
      end else begin
        act(q.pop_front());
      end
      if (unlock_wr && unlock_data[31:16] == 16'h0B16 && unlock_data[0]) m_unl = 1;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (ctrl_word !== m_ctrl) begin
        errors++; $display("FAIL %s ctrl_word got %h exp %h", m_tag, ctrl_word, m_ctrl);
      end
      if (prot_en !== m_prot) begin
        errors++; $display("FAIL R7 prot_en got %h exp %h", prot_en, m_prot);
      end
      if (done !== m_done) begin
        errors++; $display("FAIL R10 done got %b exp %b", done, m_done);
      end
      if (err !== m_err) begin
        errors++; $display("FAIL R9 err got %b exp %b", err, m_err);
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic write_key(input logic [31:0] w);
    @(negedge clk); unlock_wr = 1'b1; unlock_data = w;
    @(negedge clk); unlock_wr = 1'b0; unlock_data = '0;
  endtask

  task automatic run_seq(input logic on, output int lat, output logic e);
    @(negedge clk); req_valid = 1'b1; req_on = on;
    @(negedge clk); req_valid = 1'b0;
    lat = 1;
    while (done !== 1'b1 && lat < 500) begin @(negedge clk); lat++; end
    e = err;
    @(negedge clk);
    chk("R10 done falls after one cycle", {63'd0, done}, 64'd0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int   lat_prot, lat_skip, lat;
    logic e;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctrl_word", 64'(ctrl_word), 64'hF12);
    chk("R1 prot_en", 64'(prot_en), 64'd0);
    chk("R1 done/err", {62'd0, done, err}, 64'd0);

    // R2 locked: requests ignored, wrong keys do not unlock
    @(negedge clk); req_valid = 1; req_on = 1;
    @(negedge clk); req_valid = 0;
    idle(5);
    chk("R2 locked request ignored", 64'(ctrl_word), 64'hF12);
    write_key(32'h0B17_0001);
    write_key(32'h0B16_0000);
    @(negedge clk); req_valid = 1; req_on = 1;
    @(negedge clk); req_valid = 0;
    idle(5);
    chk("R2 bad key keeps lock", 64'(ctrl_word), 64'hF12);
    write_key(32'h0B16_0001);

    // R4/R7: power off with protection from the reset state
    cfg_sram = 4'hF; cfg_ack = 4'hF; cfg_prot = 32'h0300_0000;
    run_seq(1'b0, lat, e);
    chk("R4 off from reset err", 64'(e), 64'd0);
    chk("R7 protection engaged", 64'(prot_en), 64'h0300_0000);

    // R3/R7: power on with protection release
    run_seq(1'b1, lat_prot, e);
    chk("R3 on ctrl_word", 64'(ctrl_word), 64'h00D);
    chk("R10 on success err low", 64'(e), 64'd0);
    chk("R7 protection released", 64'(prot_en), 64'd0);

    // R4: full power off
    run_seq(1'b0, lat, e);
    chk("R4 off ctrl_word", 64'(ctrl_word), 64'hF12);
    chk("R4 off err", 64'(e), 64'd0);

    // R8: zero mask skips protection
    cfg_prot = '0;
    run_seq(1'b1, lat_skip, e);
    chk("R8 prot_en untouched", 64'(prot_en), 64'h0300_0000);
    chk("R8 skip saves two cycles", 64'(lat_prot - lat_skip), 64'd2);

    // R12: partial SRAM mask on power off
    cfg_sram = 4'b0011; cfg_ack = 4'b0001;
    run_seq(1'b0, lat, e);
    chk("R12 only masked lines set", 64'(ctrl_word), 64'h312);

    // R11: request during a running sequence ignored
    cfg_sram = 4'hF; cfg_ack = 4'hF;
    @(negedge clk); req_valid = 1; req_on = 1;
    @(negedge clk); req_valid = 0;
    idle(2);
    req_valid = 1; req_on = 0;
    @(negedge clk); req_valid = 0;
    lat = 0;
    while (done !== 1'b1 && lat < 500) begin @(negedge clk); lat++; end
    chk("R11 busy request ignored", 64'(ctrl_word), 64'h00D);
    idle(20);
    chk("R11 no second sequence", 64'(ctrl_word), 64'h00D);

    // R6: zero ack mask passes even with acknowledges stuck low
    hold_ack = 1; cfg_ack = 4'h0;
    run_seq(1'b0, lat, e);
    chk("R6 empty ack mask", {51'd0, e, ctrl_word}, 64'hF12);
    hold_ack = 0; cfg_ack = 4'hF;
    idle(2);

    // R6/R9: acknowledges stuck high time out power on
    hold_ack = 1;
    run_seq(1'b1, lat, e);
    chk("R9 ack timeout err", 64'(e), 64'd1);
    chk("R6 halted at ack wait", 64'(ctrl_word), 64'h00D);
    hold_ack = 0;
    idle(2);

    // R7/R9: protection status stuck, power off stops before SRAM step
    cfg_prot = 32'h5; hold_prot = 1;
    run_seq(1'b0, lat, e);
    chk("R9 prot timeout err", 64'(e), 64'd1);
    chk("R4 halted before SRAM", 64'(ctrl_word), 64'h00D);
    chk("R7 enables left engaged", 64'(prot_en), 64'h0300_0005);
    hold_prot = 0; cfg_prot = '0;
    idle(2);

    // R5: one status stuck off blocks the on wait
    run_seq(1'b0, lat, e);
    chk("R4 off after recovery", 64'(ctrl_word), 64'hF12);
    hold_b = 1;
    run_seq(1'b1, lat, e);
    chk("R5 mismatch not on", {51'd0, e, ctrl_word}, 64'h1F1E);
    hold_b = 0;
    idle(2);
    run_seq(1'b0, lat, e);
    chk("R5 recover to off", {51'd0, e, ctrl_word}, 64'hF12);

    // R5: one status stuck on blocks the off wait
    run_seq(1'b1, lat, e);
    chk("R3 on again", {51'd0, e, ctrl_word}, 64'h00D);
    hold_a = 1;
    run_seq(1'b0, lat, e);
    chk("R5 mismatch not off", {51'd0, e, ctrl_word}, 64'h1F12);
    hold_a = 0;
    idle(3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule